// File: doc/BRIEF.md
# Feature Frame Receiver

This block collects one frame of feature coefficients from an external feature-extraction engine. The sender raises a busy line for the length of a frame. It pulses a strobe once for each coefficient it places on a 16-bit data input. A word is taken only on a clock edge where busy and strobe are both high. Words are stored in a ten-entry buffer, in the order they arrive.

When busy drops after exactly ten words, the receiver gives a one-cycle frame-ready pulse so that the recognition code can start on the frame. A frame that ends early, or one that carries an extra word, raises an error flag instead and no ready pulse is given. The consumer reads the buffer through an index input and gets registered read data one cycle later.

Top module: `fv_frame_rx`

## Requirements
- R1: After synchronous reset, frame_ready, frame_err and rd_data are all 0.
- R2: A word is stored only on a rising clock edge where fe_busy and fe_strobe are both 1. Strobe with busy low, or busy with strobe low, stores nothing.
- R3: The n-th stored word of a frame (counting from 0) goes to buffer entry n, for n = 0 to 9.
- R4: rd_data shows the buffer entry selected by rd_idx at the previous clock edge, as it stood before any write at that edge. An index of 10 or more reads as 0.
- R5: frame_ready is high for exactly one cycle, in the cycle after the edge at which fe_busy is first seen low after being high. This happens only when ten words were stored and no error occurred in that frame.
- R6: If fe_busy falls with fewer than ten words stored, frame_err is set and no frame_ready pulse is given.
- R7: A qualified transfer after the tenth word sets frame_err. The extra word is not stored, and no frame_ready pulse follows.
- R8: A rising edge of fe_busy starts a new frame. The word count and frame_err are cleared, and the next stored word goes to entry 0. This includes a word qualified in the rising cycle itself.
- R9: Once set, frame_err stays high until the next rising edge of fe_busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_busy | input | 1 | High while the sender is transferring a frame |
| fe_strobe | input | 1 | Word-valid strobe from the sender |
| fe_word | input | 16 | Coefficient word |
| rd_idx | input | 4 | Buffer read index |
| rd_data | output | 16 | Registered buffer read data |
| frame_ready | output | 1 | One-cycle pulse when a complete frame is held |
| frame_err | output | 1 | Frame had too few or too many words |

## Verification
The receiver is driven with four kinds of frame:
- a clean ten-word frame with idle gaps, busy-without-strobe cycles and strobes outside the frame, which separates qualified from unqualified transfers;
- a short five-word frame, which shows the early-fall error and that only the low entries are overwritten;
- an eleven-word frame, which shows the overflow error and that the extra word is dropped;
- a frame whose first word arrives in the same cycle that busy rises, which checks that restart and capture happen together.

A behavioural reference model is compared with every output on every cycle. Directed read-backs through rd_idx confirm each stored position, including out-of-range indices.

// File: rtl/fv_rx_pkg.sv
package fv_rx_pkg;
    localparam int DEF_FRAME_LEN = 10;
    localparam int DEF_WORD_W    = 16;

    typedef struct packed {
        logic rise;
        logic fall;
        logic xfer;
    } bus_evt_t;

    function automatic logic count_full(input int unsigned cnt, input int unsigned len);
        return cnt == len;
    endfunction
endpackage

// File: rtl/fv_edge.sv
module fv_edge
    import fv_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     busy,
    input  logic     strobe,
    output bus_evt_t evt
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst) busy_q <= 1'b0;
        else     busy_q <= busy;
    end

    always_comb begin
        evt.rise = busy & ~busy_q;
        evt.fall = ~busy & busy_q;
        evt.xfer = busy & strobe;
    end
endmodule

// File: rtl/fv_ctrl.sv
module fv_ctrl
    import fv_rx_pkg::*;
#(
    parameter int FRAME_LEN = DEF_FRAME_LEN,
    parameter int IDX_W     = 4,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             ready,
    output logic             err
);
    logic [CNT_W-1:0] cnt, cnt_base, cnt_nxt;
    logic             err_base, err_nxt, ready_nxt, full, overflow;

    always_comb begin
        cnt_base  = evt.rise ? '0 : cnt;
        err_base  = evt.rise ? 1'b0 : err;
        full      = count_full(int'(cnt_base), FRAME_LEN);
        wr_en     = evt.xfer & ~full;
        overflow  = evt.xfer & full;
        wr_idx    = IDX_W'(cnt_base);
        cnt_nxt   = cnt_base + CNT_W'(wr_en);
        ready_nxt = evt.fall & full & ~err_base;
        err_nxt   = err_base | overflow | (evt.fall & ~(full & ~err_base));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            err   <= 1'b0;
            ready <= 1'b0;
        end else begin
            cnt   <= cnt_nxt;
            err   <= err_nxt;
            ready <= ready_nxt;
        end
    end

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= FRAME_LEN);
    a_r5_ready_single: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);
    a_r5_ready_after_fall: assert property (@(posedge clk) disable iff (rst)
        ready |-> $past(evt.fall));
    a_r6_short_frame_err: assert property (@(posedge clk) disable iff (rst)
        (evt.fall && int'(cnt) != FRAME_LEN) |=> err);
    a_r7_overflow_err: assert property (@(posedge clk) disable iff (rst)
        (evt.xfer && !evt.rise && int'(cnt) == FRAME_LEN) |=> (err && !ready));
    a_r9_err_hold: assert property (@(posedge clk) disable iff (rst)
        (err && !evt.rise) |=> err);
endmodule

// File: rtl/fv_store.sv
module fv_store #(
    parameter int DEPTH  = 10,
    parameter int WORD_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)                                 mem[g] <= '0;
            else if (wr_en && int'(wr_idx) == g)     mem[g] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                       rd_data <= '0;
        else if (int'(rd_idx) < DEPTH) rd_data <= mem[rd_idx];
        else                           rd_data <= '0;
    end

    a_r3_write_in_range: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> int'(wr_idx) < DEPTH);
endmodule

// File: rtl/fv_frame_rx.sv
module fv_frame_rx
    import fv_rx_pkg::*;
#(
    parameter int  FRAME_LEN = DEF_FRAME_LEN,
    parameter int  WORD_W    = DEF_WORD_W,
    localparam int IDX_W     = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1,
    localparam int CNT_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fe_busy,
    input  logic              fe_strobe,
    input  logic [WORD_W-1:0] fe_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic              frame_ready,
    output logic              frame_err
);
    bus_evt_t         evt;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    fv_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .busy   (fe_busy),
        .strobe (fe_strobe),
        .evt    (evt)
    );

    fv_ctrl #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .ready  (frame_ready),
        .err    (frame_err)
    );

    fv_store #(.DEPTH(FRAME_LEN), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (fe_word),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    a_r2_write_qualified: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (fe_busy && fe_strobe));
    a_r8_rise_restarts: assert property (@(posedge clk) disable iff (rst)
        (fe_busy && !$past(fe_busy) && wr_en) |-> wr_idx == '0);
    a_r6_no_ready_with_err: assert property (@(posedge clk) disable iff (rst)
        frame_ready |-> !frame_err);
endmodule

// File: tb/tb_fv_frame_rx.sv
module tb_fv_frame_rx;
    localparam int CLK_PERIOD = 10;
    localparam int N = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fe_busy = 1'b0, fe_strobe = 1'b0;
    logic [15:0] fe_word = '0;
    logic [3:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic        frame_ready, frame_err;

    int checks = 0, fails = 0;
    bit done = 0;

    fv_frame_rx dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    logic [15:0] m_buf [N];
    int          m_cnt;
    bit          m_bq, m_err, m_rdy;
    logic [15:0] m_rd;

    always @(posedge clk) begin
        bit rise, fall;
        if (rst) begin
            m_cnt = 0; m_err = 0; m_rdy = 0; m_bq = 0; m_rd = '0;
            for (int i = 0; i < N; i++) m_buf[i] = '0;
        end else begin
            rise = fe_busy && !m_bq;
            fall = !fe_busy && m_bq;
            m_rd = (int'(rd_idx) < N) ? m_buf[rd_idx] : 16'h0;
            m_rdy = 0;
            if (rise) begin m_cnt = 0; m_err = 0; end
            if (fe_busy && fe_strobe) begin
                if (m_cnt < N) begin m_buf[m_cnt] = fe_word; m_cnt++; end
                else m_err = 1;
            end
            if (fall) begin
                if (m_cnt == N && !m_err) m_rdy = 1;
                else m_err = 1;
            end
            m_bq = fe_busy;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        if (!rst) begin
            chk(frame_ready == m_rdy, "R5 ready vs model", frame_ready, m_rdy);
            chk(frame_err == m_err, "R6 R7 R9 err vs model", frame_err, m_err);
            chk(rd_data == m_rd, "R4 rd_data vs model", rd_data, m_rd);
        end
    endtask

    task automatic cyc(input bit b, input bit s, input logic [15:0] w);
        @(negedge clk);
        compare();
        fe_busy = b; fe_strobe = s; fe_word = w;
    endtask

    task automatic rd(input int i, input logic [15:0] exp, input string tag);
        cyc(0, 0, 16'h0);
        rd_idx = 4'(i);
        @(negedge clk);
        compare();
        chk(rd_data == exp, tag, rd_data, exp);
    endtask

    task automatic end_frame(input bit exp_rdy, input string tag);
        cyc(0, 0, 16'h0);
        @(negedge clk);
        compare();
        chk(frame_ready == exp_rdy, tag, frame_ready, exp_rdy);
        @(negedge clk);
        compare();
        chk(frame_ready == 1'b0, "R5 pulse one cycle", frame_ready, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(frame_ready == 0, "R1 ready reset", frame_ready, 0);
        chk(frame_err == 0, "R1 err reset", frame_err, 0);
        chk(rd_data == 0, "R1 rd_data reset", rd_data, 0);

        // R2: strobe outside a frame stores nothing
        cyc(0, 1, 16'hDEAD);
        cyc(0, 0, 16'h0);
        rd(0, 16'h0, "R2 strobe without busy ignored");

        // clean frame with gaps and busy-only cycles
        cyc(1, 0, 16'hBEEF);
        for (int k = 0; k < N; k++) begin
            cyc(1, 1, 16'h1100 + 16'(k));
            if (k % 3 == 0) cyc(1, 0, 16'hFFFF);
        end
        end_frame(1'b1, "R5 ready after ten words");
        chk(frame_err == 0, "R5 no err on clean frame", frame_err, 0);
        for (int k = 0; k < N; k++) rd(k, 16'h1100 + 16'(k), "R3 arrival order");
        rd(10, 16'h0, "R4 index 10 reads zero");
        rd(15, 16'h0, "R4 index 15 reads zero");

        // short frame
        cyc(1, 0, 16'h0);
        for (int k = 0; k < 5; k++) cyc(1, 1, 16'h2200 + 16'(k));
        end_frame(1'b0, "R6 no ready on short frame");
        chk(frame_err == 1, "R6 err on short frame", frame_err, 1);
        rd(4, 16'h2204, "R8 new frame overwrites from 0");
        rd(5, 16'h1105, "R6 higher entries untouched");
        repeat (4) cyc(0, 0, 16'h0);
        chk(frame_err == 1, "R9 err held while idle", frame_err, 1);

        // overflow frame, first word in the rising cycle
        for (int k = 0; k < N + 1; k++) cyc(1, 1, 16'h3300 + 16'(k));
        cyc(1, 0, 16'h0);
        @(negedge clk);
        chk(frame_err == 1, "R7 err on eleventh word", frame_err, 1);
        compare();
        fe_busy = 0; fe_strobe = 0;
        @(negedge clk); compare();
        chk(frame_ready == 0, "R7 no ready after overflow", frame_ready, 0);
        rd(0, 16'h3300, "R8 rise-cycle word at entry 0");
        rd(9, 16'h3309, "R7 extra word not stored");

        // recovery frame clears error
        cyc(1, 0, 16'h0);
        @(negedge clk); compare();
        chk(frame_err == 0, "R8 err cleared on rise", frame_err, 0);
        for (int k = 0; k < N; k++) cyc(1, 1, 16'h4400 + 16'(k));
        end_frame(1'b1, "R5 ready after recovery");
        rd(9, 16'h4409, "R3 last entry");
        repeat (3) cyc(0, 0, 16'h0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule